// File: doc/BRIEF.md
# Wake Event Aggregator

This block gathers wake events from sixteen sources and drives a single shared, active-low wake request. The sources form two byte-wide groups. Each group has a sticky status register that records events and an enable register that chooses which recorded events may pull the wake line. A global wake-enable bit gates the combined request. A register in the block drives the wake line, so writes to the registers cannot cause glitches on it.

All wake state sits in the always-on standby domain. Only the standby power-on reset clears it. A second reset input covers main-power, soft and hard resets. It only clears the read-data register of the byte-wide access port. Software reads a status register to find which sources fired. It clears a status bit by writing a 1 to that bit position. In the second group, source index 11 (bit 3) carries a grouped device-interrupt request instead of a pin event.

Top module: `pme_wake_agg`

## Requirements
- R1: `wake_n` is a registered output. It is low in the cycle after a cycle in which the global enable is 1 and at least one source has both its status bit and its enable bit set. Otherwise it is high.
- R2: A rising edge on `src_evt[i]` sets status bit `i`. This happens whether or not enable bit `i` is set. A masked source sets its status bit but leaves `wake_n` high.
- R3: Writing 1 to a status bit position clears that bit. Writing 0 leaves the bit unchanged. If a rising edge and a clearing write hit the same bit in the same cycle, the bit stays set.
- R4: The two enable registers are at 0x0B and 0x0C, and both can be read and written. Bit i of 0x0B enables source i. Bit i of 0x0C enables source 8+i. Bit 3 of 0x0C (source 11) is the grouped device-interrupt source.
- R5: Asserting `rst_main_n` low leaves the status, enable and global-enable registers unchanged. It clears `reg_rdata` to 0x00.
- R6: A cycle with `reg_rd` high loads `reg_rdata` on the next edge with the register at `reg_addr`, read before any same-cycle write. Status group 0 is at 0x08, status group 1 at 0x09, and the global enable is bit 0 of 0x0A (other bits read 0). `reg_rdata` holds its value when `reg_rd` is low.
- R7: Reading an offset other than 0x08 to 0x0C returns 0x00. Writing such an offset changes nothing.
- R8: While `rst_stby_n` is low, all status, enable and global-enable bits clear and `wake_n` is high. While the global enable is 0, `wake_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_stby_n | input | 1 | Standby power-on reset, synchronous, active low |
| rst_main_n | input | 1 | Main-power/soft/hard reset, synchronous, active low |
| src_evt | input | 16 | Wake event inputs, synchronous to clk; index 11 is the device-interrupt source |
| reg_addr | input | 8 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| wake_n | output | 1 | Shared active-low wake request |

## Verification
The bench uses the default build: two groups of eight sources and byte-wide registers. With this build every status and enable bit can be reached through the five implemented offsets, and the device-interrupt position is bit 3 of the second group. Random traffic mixes the implemented offsets with unimplemented ones (0x00, 0x07, 0x0D, 0xFF), toggling events and occasional main resets. This exercises same-cycle set/clear collisions, reads during writes and masked events. Directed steps pin down the reset state, the enable mapping and whether state survives a main reset.

// File: rtl/pme_wake_pkg.sv
// Shared constants for the wake event aggregator.
// Assumes register offsets fit in an 8-bit address.
package pme_wake_pkg;
    localparam int unsigned STAT_BASE = 8'h08;  // status of group g at STAT_BASE+g
    localparam int unsigned CTRL_OFS  = 8'h0A;  // global wake enable, bit 0
    localparam int unsigned EN_BASE   = 8'h0B;  // enable of group g at EN_BASE+g
    localparam int unsigned CTRL_MASK = 1;      // writable bits of the control register
endpackage

// File: rtl/pme_wake_grp.sv
// One source group: edge detection, sticky status with write-1-clear,
// and a per-source enable register. All state is in the standby domain.
// Assumes src_evt is already synchronous to clk.
module pme_wake_grp #(
    parameter int unsigned GW = 8
) (
    input  logic          clk,
    input  logic          rst_stby_n,
    input  logic [GW-1:0] src_evt,
    input  logic          stat_wr,
    input  logic          en_wr,
    input  logic [GW-1:0] wdata,
    output logic [GW-1:0] stat_q,
    output logic [GW-1:0] en_q,
    output logic          term
);
    logic [GW-1:0] prev_q;
    logic [GW-1:0] rise;
    logic [GW-1:0] clr_mask;

    assign rise     = src_evt & ~prev_q;
    assign clr_mask = stat_wr ? wdata : '0;
    assign term     = |(stat_q & en_q);

    // Remember last event level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_stby_n) prev_q <= '0;
        else             prev_q <= src_evt;
    end

    // Sticky status: new edges win over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_stby_n) stat_q <= '0;
        else             stat_q <= (stat_q & ~clr_mask) | rise;
    end

    // Enable register, written whole.
    always_ff @(posedge clk) begin
        if (!rst_stby_n)  en_q <= '0;
        else if (en_wr)   en_q <= wdata;
    end

    // R2: every rising edge shows up in status on the next cycle
    a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_stby_n)
        (|rise) |=> ((stat_q & $past(rise)) == $past(rise)));

    // R3: set bits not cleared by a write stay set
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_stby_n)
        (|(stat_q & ~clr_mask)) |=> ((stat_q & $past(stat_q & ~clr_mask)) == $past(stat_q & ~clr_mask)));

    // R5: enables move only on a write to them
    a_r5_en_hold: assert property (@(posedge clk) disable iff (!rst_stby_n)
        !en_wr |=> $stable(en_q));
endmodule

// File: rtl/pme_wake_drv.sv
// Combines group requests, gates them with the global enable and
// registers the active-low wake output so it cannot glitch.
module pme_wake_drv #(
    parameter int unsigned NGRP = 2
) (
    input  logic            clk,
    input  logic            rst_stby_n,
    input  logic            glob_en,
    input  logic [NGRP-1:0] term,
    output logic            wake_n
);
    logic req;

    assign req = glob_en & (|term);

    // Registered, inverted wake request.
    always_ff @(posedge clk) begin
        if (!rst_stby_n) wake_n <= 1'b1;
        else             wake_n <= ~req;
    end

    // R1: an active term under global enable pulls the line next cycle
    a_r1_assert: assert property (@(posedge clk) disable iff (!rst_stby_n)
        req |=> !wake_n);

    // R8: without global enable or any term the line is released
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_stby_n)
        !req |=> wake_n);
endmodule

// File: rtl/pme_wake_agg.sv
// Wake event aggregator top: source groups, global enable, byte-wide
// register port with registered read data, and the shared wake output.
// Assumes single-cycle read/write strobes synchronous to clk.
module pme_wake_agg
    import pme_wake_pkg::*;
#(
    parameter int unsigned NGRP = 2,
    parameter int unsigned GW   = 8,
    parameter int unsigned AW   = 8
) (
    input  logic               clk,
    input  logic               rst_stby_n,
    input  logic               rst_main_n,
    input  logic [NGRP*GW-1:0] src_evt,
    input  logic [AW-1:0]      reg_addr,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [GW-1:0]      reg_wdata,
    output logic [GW-1:0]      reg_rdata,
    output logic               wake_n
);
    localparam logic [AW-1:0] CTRL_A = AW'(CTRL_OFS);
    localparam logic [GW-1:0] CMASK  = GW'(CTRL_MASK);

    logic [GW-1:0]   stat_a [NGRP];
    logic [GW-1:0]   en_a   [NGRP];
    logic [NGRP-1:0] term;
    logic [NGRP-1:0] hit_stat;
    logic [NGRP-1:0] hit_en;
    logic [GW-1:0]   ctrl_q;
    logic [GW-1:0]   rmux;
    logic            hit_any;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign hit_stat[g] = (reg_addr == AW'(STAT_BASE + g));
        assign hit_en[g]   = (reg_addr == AW'(EN_BASE + g));

        pme_wake_grp #(.GW(GW)) u_grp (
            .clk        (clk),
            .rst_stby_n (rst_stby_n),
            .src_evt    (src_evt[g*GW +: GW]),
            .stat_wr    (reg_wr & hit_stat[g]),
            .en_wr      (reg_wr & hit_en[g]),
            .wdata      (reg_wdata),
            .stat_q     (stat_a[g]),
            .en_q       (en_a[g]),
            .term       (term[g])
        );
    end

    // Global wake enable, standby domain; reserved bits stay zero.
    always_ff @(posedge clk) begin
        if (!rst_stby_n)                       ctrl_q <= '0;
        else if (reg_wr && reg_addr == CTRL_A) ctrl_q <= reg_wdata & CMASK;
    end

    // Read multiplexer over all implemented offsets.
    always_comb begin
        rmux    = '0;
        hit_any = (reg_addr == CTRL_A);
        if (reg_addr == CTRL_A) rmux = ctrl_q;
        for (int g = 0; g < NGRP; g++) begin
            if (hit_stat[g]) rmux = stat_a[g];
            if (hit_en[g])   rmux = en_a[g];
            hit_any = hit_any | hit_stat[g] | hit_en[g];
        end
    end

    // Read data register, main-power domain.
    always_ff @(posedge clk) begin
        if (!rst_main_n)  reg_rdata <= '0;
        else if (reg_rd)  reg_rdata <= rmux;
    end

    pme_wake_drv #(.NGRP(NGRP)) u_drv (
        .clk        (clk),
        .rst_stby_n (rst_stby_n),
        .glob_en    (ctrl_q[0]),
        .term       (term),
        .wake_n     (wake_n)
    );

    // R7: reads of unimplemented offsets return zero
    a_r7_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_main_n)
        (reg_rd && !hit_any) |=> (reg_rdata == '0));

    // R6: read data holds while no read is issued
    a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_main_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/sim_pme_wake_agg.sv
module sim_pme_wake_agg;
    logic        clk = 1'b0;
    logic        rst_stby_n, rst_main_n;
    logic [15:0] src_evt;
    logic [7:0]  reg_addr, reg_wdata, reg_rdata;
    logic        reg_wr, reg_rd, wake_n;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench model
    logic [15:0] m_stat, m_en, m_prev;
    logic        m_gen, m_wake;
    logic [7:0]  m_rdata;

    always #10 clk = ~clk;

    pme_wake_agg u0 (
        .clk(clk), .rst_stby_n(rst_stby_n), .rst_main_n(rst_main_n),
        .src_evt(src_evt), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wake_n(wake_n)
    );

    function automatic logic [7:0] f_rmux(input logic [7:0] a);
        case (a)
            8'h08:   return m_stat[7:0];
            8'h09:   return m_stat[15:8];
            8'h0A:   return {7'b0, m_gen};
            8'h0B:   return m_en[7:0];
            8'h0C:   return m_en[15:8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic f_wake();
        return !(m_gen && |(m_stat & m_en));
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: update model at the edge, compare at the falling edge
    task automatic tick();
        logic [15:0] rise, clr;
        @(posedge clk);
        if (!rst_main_n)  m_rdata = 8'h00;
        else if (reg_rd)  m_rdata = f_rmux(reg_addr);
        if (!rst_stby_n) begin
            m_wake = 1'b1; m_stat = '0; m_en = '0; m_prev = '0; m_gen = 1'b0;
        end else begin
            m_wake = f_wake();
            rise   = src_evt & ~m_prev;
            m_prev = src_evt;
            clr    = '0;
            if (reg_wr && reg_addr == 8'h08) clr[7:0]  = reg_wdata;
            if (reg_wr && reg_addr == 8'h09) clr[15:8] = reg_wdata;
            m_stat = (m_stat & ~clr) | rise;
            if (reg_wr && reg_addr == 8'h0B) m_en[7:0]  = reg_wdata;
            if (reg_wr && reg_addr == 8'h0C) m_en[15:8] = reg_wdata;
            if (reg_wr && reg_addr == 8'h0A) m_gen = reg_wdata[0];
        end
        @(negedge clk);
        chk({7'b0, wake_n}, {7'b0, m_wake}, "R1 wake_n vs model");
        chk(reg_rdata, m_rdata, "R6 rdata vs model");
    endtask

    task automatic idle();
        reg_wr = 0; reg_rd = 0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1; reg_rd = 0;
        tick(); idle();
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1; reg_wr = 0;
        tick(); idle(); d = reg_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rd;
        void'($urandom(32'd1234));
        rst_stby_n = 0; rst_main_n = 0; src_evt = '0;
        reg_addr = '0; reg_wdata = '0; idle();
        m_stat = '0; m_en = '0; m_prev = '0; m_gen = 0; m_wake = 1; m_rdata = '0;
        @(negedge clk);
        repeat (3) tick();
        rst_stby_n = 1; rst_main_n = 1;
        tick();

        // R8: reset state
        chk({7'b0, wake_n}, 8'h01, "R8 wake_n after reset");
        for (int a = 8; a <= 12; a++) begin
            do_read(8'(a), rd);
            chk(rd, 8'h00, "R8 register after standby reset");
        end

        // R2: masked event recorded, no wake
        do_write(8'h0A, 8'h01);
        src_evt[2] = 1; tick();
        do_read(8'h08, rd);
        chk(rd, 8'h04, "R2 masked status set");
        chk({7'b0, wake_n}, 8'h01, "R2 masked source no wake");

        // R1: enable it, wake falls one cycle after
        do_write(8'h0B, 8'h04);
        tick();
        chk({7'b0, wake_n}, 8'h00, "R1 wake asserted");

        // R8: global gate
        do_write(8'h0A, 8'h00);
        tick();
        chk({7'b0, wake_n}, 8'h01, "R8 global enable off");
        do_write(8'h0A, 8'h01);

        // R3: write-0 keeps, write-1 clears, set beats clear
        do_write(8'h08, 8'h00);
        do_read(8'h08, rd);
        chk(rd, 8'h04, "R3 write 0 keeps");
        do_write(8'h08, 8'h04);
        do_read(8'h08, rd);
        chk(rd, 8'h00, "R3 write 1 clears");
        src_evt[2] = 0; tick();
        src_evt[2] = 1;
        do_write(8'h08, 8'h04);
        do_read(8'h08, rd);
        chk(rd, 8'h04, "R3 set wins over clear");
        do_write(8'h0B, 8'h00);
        do_write(8'h08, 8'hFF);

        // R4: device-interrupt position in group 1
        do_write(8'h0C, 8'h08);
        src_evt[11] = 1; tick();
        do_read(8'h09, rd);
        chk(rd, 8'h08, "R4 source 11 status");
        chk({7'b0, wake_n}, 8'h00, "R4 source 11 wakes");
        do_read(8'h0C, rd);
        chk(rd, 8'h08, "R4 enable readback");
        do_write(8'h0B, 8'h04);

        // R5: main reset keeps wake state, clears read data
        rst_main_n = 0; tick();
        chk(reg_rdata, 8'h00, "R5 rdata cleared by main reset");
        tick(); rst_main_n = 1;
        do_read(8'h0B, rd); chk(rd, 8'h04, "R5 enable 0 kept");
        do_read(8'h0C, rd); chk(rd, 8'h08, "R5 enable 1 kept");
        do_read(8'h0A, rd); chk(rd, 8'h01, "R5 global kept");
        do_read(8'h09, rd); chk(rd, 8'h08, "R5 status kept");

        // R7: unimplemented offsets
        do_write(8'h0D, 8'hFF);
        do_write(8'h00, 8'hFF);
        do_read(8'h0D, rd); chk(rd, 8'h00, "R7 unimplemented read 0x0D");
        do_read(8'h00, rd); chk(rd, 8'h00, "R7 unimplemented read 0x00");
        do_read(8'h0B, rd); chk(rd, 8'h04, "R7 enable untouched");

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            case ($urandom % 10)
                0: reg_addr = 8'h00;
                1: reg_addr = 8'h07;
                2: reg_addr = 8'h0D;
                3: reg_addr = 8'hFF;
                4: reg_addr = 8'h0A;
                5, 6: reg_addr = 8'h08 + 8'($urandom % 2);
                default: reg_addr = 8'h0B + 8'($urandom % 2);
            endcase
            reg_wdata  = 8'($urandom);
            reg_wr     = ($urandom % 10) < 3;
            reg_rd     = ($urandom % 2) == 1;
            rst_main_n = ($urandom % 40) != 0;
            if (($urandom % 4) == 0) src_evt = src_evt ^ (16'h1 << ($urandom % 16));
            tick();
        end
        idle(); rst_main_n = 1;
        tick();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule